// File: doc/BRIEF.md
# Single-Bus Register Transfer Sequencer

This block holds a small register file of five N-bit registers that are all joined by one shared bus. A single source multiplexer, steered by a 3-bit select, places one register on the bus in each cycle. Any subset of registers can capture the bus value on the same clock edge, so one source can broadcast to several destinations at once. Because the bus can carry only one source per cycle, a Moore controller breaks each requested operation into one or more single-bus steps. Each step lasts exactly one clock cycle.

A client issues a command with a one-cycle start strobe. The command carries an opcode, a source index, a destination mask and, for loads, a data word. A move copies the source register into every masked register in one step. A swap exchanges two registers in three steps and uses register 4 as the temporary. A load writes the data word into every masked register in one step. The `busy` output is high during the steps. A one-cycle `done` pulse follows the last step, and a new command may start in that same cycle.

Top module: `regBusSeq`

## Requirements
- R1: A synchronous reset clears all five registers to zero and returns the controller to idle, with `busy` and `done` low.
- R2: A move (opcode 00) with source index s copies register s into every register whose bit is set in `cmdMask`, where bit i stands for register i. It takes one state, and registers outside the mask keep their values.
- R3: Two moves with different sources are serialised as two separate commands, one bus state each. For example, register 1 to register 0 and then register 2 to register 3 leaves both destinations holding the original source values.
- R4: A swap (opcode 01) of register s with the single register named by a one-hot `cmdMask` runs three states in this order: s to register 4, the other register to s, register 4 to the other register. Register 4 ends up holding the original value of s.
- R5: The bus select holds the binary index of the source register (001 is register 1, 100 is register 4). Codes 101 to 111 put zero on the bus, and no register loads from the bus in a cycle that uses such a code.
- R6: A move whose mask is empty or contains only its own source completes in one state and changes no register.
- R7: A load (opcode 10) writes `cmdData` into every masked register in one state.
- R8: A command is ignored, so that `busy` stays low, no `done` follows and no register changes, if any of these holds: the opcode is 11, a move source index is above 4, a swap source is 4, or a swap mask is not one-hot, names register 4 or names its own source.
- R9: A start strobe that arrives while `busy` is high is ignored.
- R10: `done` is high for exactly one cycle, in the cycle after the last state, and `busy` is low in that cycle. A move or load has its `done` two edges after the accepting edge, and a swap has it four edges after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmdStart | input | 1 | Command strobe, sampled when `busy` is low |
| cmdOp | input | 2 | 00 move, 01 swap, 10 load, 11 reserved |
| cmdSrc | input | 3 | Source register index (first swap operand) |
| cmdMask | input | 5 | Destination mask; bit i is register i |
| cmdData | input | N | Data word for a load |
| busy | output | 1 | High while the transfer steps run |
| done | output | 1 | One-cycle pulse after the last step |
| regFlat | output | 5*N | Register i on bits [i*N +: N] |

## Verification
The hardest situation to create from the ports is a start strobe that arrives while a multi-step swap is in flight. Here a badly gated controller would latch new operands halfway through the swap and corrupt the temporary. The stimulus holds the strobe high with a full-mask load across the first two swap steps. It then releases the strobe before the `done` cycle and checks that only the swap's result appears. Commands that must be rejected are mixed in as well, and the bench confirms that no `busy`, no `done` and no register change appear over several following cycles.

// File: rtl/regBusPkg.sv
package regBusPkg;
  localparam int NUM_REGS = 5;
  localparam int SEL_W    = 3;
  localparam int OP_W     = 2;
  localparam logic [SEL_W-1:0] TEMP_IDX  = 3'd4;
  localparam logic [SEL_W-1:0] NULL_SEL  = 3'd7;

  typedef enum logic [OP_W-1:0] {
    OP_MOVE = 2'b00,
    OP_SWAP = 2'b01,
    OP_LOAD = 2'b10,
    OP_RSVD = 2'b11
  } opcode_e;

  typedef struct packed {
    logic [SEL_W-1:0]    busSel;
    logic [NUM_REGS-1:0] loadMask;
    logic                useExt;
    logic                capture;
  } dpStrobes_t;
endpackage

// File: rtl/regBusDatapath.sv
module regBusDatapath
  import regBusPkg::*;
#(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpStrobes_t            strobe,
  input  logic [N-1:0]          extData,
  output logic [NUM_REGS*N-1:0] regFlat
);
  logic [N-1:0] regQ [NUM_REGS];
  logic [N-1:0] extHold;
  logic [N-1:0] busVal;
  logic [N-1:0] loadVal;

  // Single shared bus: unused select codes leave it at zero.
  always_comb begin
    busVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.busSel == SEL_W'(i)) busVal = regQ[i];
    end
  end

  assign loadVal = strobe.useExt ? extHold : busVal;

  always_ff @(posedge clk) begin
    if (rst)                 extHold <= '0;
    else if (strobe.capture) extHold <= extData;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (rst)                     regQ[g] <= '0;
      else if (strobe.loadMask[g]) regQ[g] <= loadVal;
    end
    assign regFlat[g*N +: N] = regQ[g];

    // R2: a register outside the load mask keeps its value
    a_r2_unloaded_hold: assert property (@(posedge clk) disable iff (rst)
      !strobe.loadMask[g] |=> $stable(regQ[g]));
  end

  // R5: never load from the bus while it carries an unused select code
  a_r5_no_load_on_null_code: assert property (@(posedge clk) disable iff (rst)
    ((|strobe.loadMask) && !strobe.useExt) |-> (strobe.busSel < SEL_W'(NUM_REGS)));
endmodule

// File: rtl/regBusControl.sv
module regBusControl
  import regBusPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cmdStart,
  input  logic [OP_W-1:0]     cmdOp,
  input  logic [SEL_W-1:0]    cmdSrc,
  input  logic [NUM_REGS-1:0] cmdMask,
  output dpStrobes_t          strobe,
  output logic                busy,
  output logic                done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_MOVE, ST_LOAD, ST_SW1, ST_SW2, ST_SW3, ST_DONE
  } state_e;

  state_e              state, stateNext;
  logic [SEL_W-1:0]    srcQ, otherQ, maskIdx;
  logic [NUM_REGS-1:0] maskQ;
  logic                cmdOk, accept;

  always_comb begin
    maskIdx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (cmdMask[i]) maskIdx = SEL_W'(i);
    end
  end

  always_comb begin
    unique case (opcode_e'(cmdOp))
      OP_MOVE: cmdOk = cmdSrc < SEL_W'(NUM_REGS);
      OP_SWAP: cmdOk = (cmdSrc < TEMP_IDX) && ($countones(cmdMask) == 1)
                       && !cmdMask[TEMP_IDX] && (maskIdx != cmdSrc);
      OP_LOAD: cmdOk = 1'b1;
      default: cmdOk = 1'b0;
    endcase
  end

  assign busy   = (state != ST_IDLE) && (state != ST_DONE);
  assign done   = (state == ST_DONE);
  assign accept = cmdStart && !busy && cmdOk;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        stateNext = ST_IDLE;
        if (accept) begin
          unique case (opcode_e'(cmdOp))
            OP_MOVE: stateNext = ST_MOVE;
            OP_SWAP: stateNext = ST_SW1;
            default: stateNext = ST_LOAD;
          endcase
        end
      end
      ST_SW1:  stateNext = ST_SW2;
      ST_SW2:  stateNext = ST_SW3;
      default: stateNext = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      srcQ   <= '0;
      otherQ <= '0;
      maskQ  <= '0;
    end else begin
      state <= stateNext;
      if (accept) begin
        srcQ   <= cmdSrc;
        otherQ <= maskIdx;
        maskQ  <= cmdMask;
      end
    end
  end

  // Moore strobes: depend on state and latched operands only (capture aside).
  always_comb begin
    strobe          = '0;
    strobe.busSel   = NULL_SEL;
    strobe.capture  = accept;
    unique case (state)
      ST_MOVE: begin
        strobe.busSel   = srcQ;
        strobe.loadMask = maskQ;
      end
      ST_LOAD: begin
        strobe.useExt   = 1'b1;
        strobe.loadMask = maskQ;
      end
      ST_SW1: begin
        strobe.busSel   = srcQ;
        strobe.loadMask = NUM_REGS'(1) << TEMP_IDX;
      end
      ST_SW2: begin
        strobe.busSel   = otherQ;
        strobe.loadMask = NUM_REGS'(1) << srcQ;
      end
      ST_SW3: begin
        strobe.busSel   = TEMP_IDX;
        strobe.loadMask = NUM_REGS'(1) << otherQ;
      end
      default: ;
    endcase
  end

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: swap steps run in fixed order
  a_r4_swap_step2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SW1) |=> (state == ST_SW2));
  a_r4_swap_step3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SW2) |=> (state == ST_SW3));
  // R8: a rejected command leaves the controller idle
  a_r8_reject_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && cmdStart && !cmdOk) |=> !busy);
  // R9: a strobe during a single-step op does not extend it
  a_r9_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MOVE || state == ST_LOAD) |=> done);
endmodule

// File: rtl/regBusSeq.sv
module regBusSeq
  import regBusPkg::*;
#(
  parameter int N = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmdStart,
  input  logic [1:0]            cmdOp,
  input  logic [2:0]            cmdSrc,
  input  logic [4:0]            cmdMask,
  input  logic [N-1:0]          cmdData,
  output logic                  busy,
  output logic                  done,
  output logic [5*N-1:0]        regFlat
);
  dpStrobes_t strobe;

  regBusControl ctrl_i (
    .clk(clk), .rst(rst), .cmdStart(cmdStart), .cmdOp(cmdOp),
    .cmdSrc(cmdSrc), .cmdMask(cmdMask), .strobe(strobe),
    .busy(busy), .done(done)
  );

  regBusDatapath #(.N(N)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .extData(cmdData),
    .regFlat(regFlat)
  );
endmodule

// File: tb/regBusSeq_tb_top.sv
`timescale 1ns/1ps
module regBusSeq_tb_top;
  localparam int N = 8;
  localparam int NV = 12;
  // vector: {op[2], src[3], mask[5], data[8], edges[3]}
  localparam logic [20:0] VEC [NV] = '{
    {2'd2, 3'd0, 5'b00001, 8'h11, 3'd2},  // R7 load
    {2'd2, 3'd0, 5'b00010, 8'h22, 3'd2},  // R7
    {2'd2, 3'd0, 5'b00100, 8'h33, 3'd2},  // R7
    {2'd2, 3'd0, 5'b01000, 8'h44, 3'd2},  // R7
    {2'd2, 3'd0, 5'b10000, 8'h55, 3'd2},  // R7
    {2'd0, 3'd1, 5'b00001, 8'h00, 3'd2},  // R3 first move
    {2'd0, 3'd2, 5'b01000, 8'h00, 3'd2},  // R3 second move
    {2'd1, 3'd1, 5'b00100, 8'h00, 3'd4},  // R4 swap 1<->2
    {2'd0, 3'd0, 5'b10110, 8'h00, 3'd2},  // R2 broadcast
    {2'd0, 3'd3, 5'b01000, 8'h00, 3'd2},  // R6 self move
    {2'd0, 3'd2, 5'b00000, 8'h00, 3'd2},  // R6 empty mask
    {2'd1, 3'd3, 5'b00001, 8'h00, 3'd4}   // R4 swap 3<->0
  };

  logic clk = 0, rst = 1, cmdStart = 0;
  logic [1:0] cmdOp = 0;
  logic [2:0] cmdSrc = 0;
  logic [4:0] cmdMask = 0;
  logic [N-1:0] cmdData = 0;
  logic busy, done;
  logic [5*N-1:0] regFlat;
  logic [N-1:0] expR [5];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  regBusSeq #(.N(N)) dut_i (
    .clk(clk), .rst(rst), .cmdStart(cmdStart), .cmdOp(cmdOp),
    .cmdSrc(cmdSrc), .cmdMask(cmdMask), .cmdData(cmdData),
    .busy(busy), .done(done), .regFlat(regFlat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    for (int i = 0; i < 5; i++) chk(tag, int'(regFlat[i*N +: N]), int'(expR[i]));
  endtask

  function automatic void model(input logic [1:0] op, input logic [2:0] s,
                                input logic [4:0] m, input logic [N-1:0] d);
    logic [N-1:0] t;
    int o = 0;
    if (op == 2'd0) begin
      t = expR[s];
      for (int i = 0; i < 5; i++) if (m[i]) expR[i] = t;
    end else if (op == 2'd1) begin
      for (int i = 0; i < 5; i++) if (m[i]) o = i;
      t = expR[s];
      expR[4] = t;
      expR[s] = expR[o];
      expR[o] = t;
    end else if (op == 2'd2) begin
      for (int i = 0; i < 5; i++) if (m[i]) expR[i] = d;
    end
  endfunction

  task automatic drive(input logic [1:0] op, input logic [2:0] s,
                       input logic [4:0] m, input logic [N-1:0] d);
    cmdOp = op; cmdSrc = s; cmdMask = m; cmdData = d; cmdStart = 1;
  endtask

  // run an accepted command; returns edges from the accepting edge to done
  task automatic runCmd(input logic [1:0] op, input logic [2:0] s,
                        input logic [4:0] m, input logic [N-1:0] d,
                        output int edges);
    @(negedge clk); drive(op, s, m, d);
    @(posedge clk); @(negedge clk); cmdStart = 0;
    edges = 1;
    while (!done && edges < 20) begin
      @(posedge clk); @(negedge clk); edges++;
    end
  endtask

  task automatic tryReject(input string tag, input logic [1:0] op,
                           input logic [2:0] s, input logic [4:0] m);
    @(negedge clk); drive(op, s, m, 8'hEE);
    @(posedge clk); @(negedge clk); cmdStart = 0;
    chk({tag, " busy"}, int'(busy), 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk({tag, " done"}, int'(done | busy), 0);
    end
    chkRegs({tag, " regs"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int edges;
    for (int i = 0; i < 5; i++) expR[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chkRegs("R1 reset regs");
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);

    // vector walk (R2 R3 R4 R6 R7 R10)
    for (int v = 0; v < NV; v++) begin
      runCmd(VEC[v][20:19], VEC[v][18:16], VEC[v][15:11], VEC[v][10:3], edges);
      model(VEC[v][20:19], VEC[v][18:16], VEC[v][15:11], VEC[v][10:3]);
      chk($sformatf("R10 vec%0d edges", v), edges, int'(VEC[v][2:0]));
      chk($sformatf("R10 vec%0d busy at done", v), int'(busy), 0);
      chkRegs($sformatf("R2/R4/R7 vec%0d regs", v));
      @(posedge clk); @(negedge clk);
      chk($sformatf("R10 vec%0d done pulse", v), int'(done), 0);
    end

    // R8 rejected commands
    tryReject("R8 reserved op", 2'd3, 3'd0, 5'b00001);
    tryReject("R8 move src 5", 2'd0, 3'd5, 5'b00001);
    tryReject("R8 swap src 4", 2'd1, 3'd4, 5'b00001);
    tryReject("R8 swap two bits", 2'd1, 3'd0, 5'b00110);
    tryReject("R8 swap with r4", 2'd1, 3'd0, 5'b10000);
    tryReject("R8 swap self", 2'd1, 3'd2, 5'b00100);

    // R9 strobe during a swap is ignored
    @(negedge clk); drive(2'd1, 3'd0, 5'b00100, 8'h00);
    @(posedge clk); @(negedge clk);
    drive(2'd2, 3'd0, 5'b11111, 8'hFF);
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); cmdStart = 0;
    @(posedge clk); @(negedge clk);
    model(2'd1, 3'd0, 5'b00100, 8'h00);
    chk("R9 done after swap", int'(done), 1);
    chkRegs("R9 regs");
    @(posedge clk); @(negedge clk);
    chk("R9 no late start", int'(busy), 0);

    // R1 reset in the middle of an operation
    @(negedge clk); drive(2'd0, 3'd1, 5'b11111, 8'h00);
    @(posedge clk); @(negedge clk); cmdStart = 0; rst = 1;
    @(posedge clk); @(negedge clk); rst = 0;
    for (int i = 0; i < 5; i++) expR[i] = '0;
    chkRegs("R1 mid reset regs");
    chk("R1 mid reset busy", int'(busy | done), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule